// File: doc/BRIEF.md
# DRAM Partial-Write Mask and Read-Modify-Write Selector

This block sits between a memory write request port and the DRAM data path. Each accepted write carries eight data bytes and a per-byte enable. The block issues it either as a single write command with per-lane data masks, or as a full-line read followed by a merged full-line write with every byte active. The choice depends on the write's byte enables and on the device organisation input.

The line has nine byte lanes. Lanes 0 to 7 carry data and lane 8 carries a check byte. With wide devices (x8/x16), the mask pins mask bytes directly. With narrow devices (x4), the mask pins are reused as extra data strobes, so there is no masking. In that mode any partial write goes through read-modify-write. The check byte is a placeholder code: the XOR of the eight data bytes of the line being written. While a read-modify-write is pending, the request port is held not-ready.

Top module: `wmask_rmw_sel`

## Requirements
- R1: After reset, cmd_valid_o and dm_oe_o are 0 and req_ready_o is 1.
- R2: In wide mode (x4_mode_i=0), a partial write is issued as one write command in the cycle after acceptance. dm_o[i] = ~req_be_i[i] for lanes 0..7, and dm_o[8] = 1 (check lane masked; 1 means masked). Lane i of wr_data_o is bits [8i+7:8i] and carries request byte i.
- R3: A write with all eight enables set gives a single write command in either mode. Its dm_o is all zero and its lane 8 is the XOR of the eight data bytes.
- R4: In narrow mode (x4_mode_i=1), a partial write gives a read command (cmd_wr_o=0) at the request address in the cycle after acceptance. req_ready_o is 0 from that cycle until the merged write is issued.
- R5: The cycle after rd_valid_i is seen during a pending read-modify-write, the block issues a write with dm_o all zero. Each enabled byte comes from the held request data and each other byte from rd_data_i.
- R6: The lane 8 of a merged write is the XOR of the eight merged data bytes.
- R7: dm_oe_o is 1 exactly in cycles carrying a write command, and 0 at all other times.
- R8: In narrow mode every write command has dm_o all zero.
- R9: req_valid_i is ignored while a read-modify-write is pending. rd_valid_i is ignored when no read-modify-write is pending. Neither produces a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x4_mode_i | input | 1 | 1: narrow devices, mask pins used as strobes |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Request port ready |
| req_addr_i | input | 32 | Write line address |
| req_data_i | input | 64 | Write data, byte i at [8i+7:8i] |
| req_be_i | input | 8 | Byte enables for data lanes |
| rd_valid_i | input | 1 | Read data return valid |
| rd_data_i | input | 64 | Read return data bytes |
| cmd_valid_o | output | 1 | Command valid, one cycle |
| cmd_wr_o | output | 1 | 1: write command, 0: read command |
| cmd_addr_o | output | 32 | Command address |
| wr_data_o | output | 72 | Write line, lane 8 is check byte |
| dm_o | output | 9 | Per-lane mask, 1 = masked |
| dm_oe_o | output | 1 | Drive enable for mask/strobe pins |

## Verification
The assertions assume that x4_mode_i stays constant while a read-modify-write is pending. They also assume that rd_valid_i returns only after a read command. The bench changes the mode only between idle requests and pulses rd_valid_i only after observing the read command. The exception is one deliberate stray pulse while idle, which the block must ignore. The bench also raises req_valid_i while a read-modify-write is pending. This is legal stimulus that checks the port is held off.

// File: rtl/wmask_pkg.sv
package wmask_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} wm_state_e;
endpackage

// File: rtl/wmask_merge.sv
module wmask_merge #(
  parameter int DATA_LANES = 8,
  parameter int LANE_W     = 8,
  localparam int DATA_W    = DATA_LANES * LANE_W
) (
  input  logic [DATA_W-1:0]     new_i,
  input  logic [DATA_W-1:0]     old_i,
  input  logic [DATA_LANES-1:0] be_i,
  output logic [DATA_W-1:0]     merged_o
);
  for (genvar g = 0; g < DATA_LANES; g++) begin : g_lane
    assign merged_o[g*LANE_W +: LANE_W] = be_i[g] ? new_i[g*LANE_W +: LANE_W]
                                                  : old_i[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/wmask_check.sv
module wmask_check #(
  parameter int DATA_LANES = 8,
  parameter int LANE_W     = 8,
  localparam int DATA_W    = DATA_LANES * LANE_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [LANE_W-1:0] chk_o
);
  // placeholder code: byte-wise XOR fold
  logic [LANE_W-1:0] acc [DATA_LANES+1];
  assign acc[0] = '0;
  for (genvar g = 0; g < DATA_LANES; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ data_i[g*LANE_W +: LANE_W];
  end
  assign chk_o = acc[DATA_LANES];
endmodule

// File: rtl/wmask_rmw_sel.sv
module wmask_rmw_sel
  import wmask_pkg::*;
#(
  parameter int DATA_LANES = 8,
  parameter int LANE_W     = 8,
  parameter int ADDR_W     = 32,
  localparam int LANES     = DATA_LANES + 1,
  localparam int DATA_W    = DATA_LANES * LANE_W,
  localparam int LINE_W    = LANES * LANE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  x4_mode_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_data_i,
  input  logic [DATA_LANES-1:0] req_be_i,
  input  logic                  rd_valid_i,
  input  logic [DATA_W-1:0]     rd_data_i,
  output logic                  cmd_valid_o,
  output logic                  cmd_wr_o,
  output logic [ADDR_W-1:0]     cmd_addr_o,
  output logic [LINE_W-1:0]     wr_data_o,
  output logic [LANES-1:0]      dm_o,
  output logic                  dm_oe_o
);
  wm_state_e               state_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [DATA_W-1:0]       data_q;
  logic [DATA_LANES-1:0]   be_q;
  logic [DATA_W-1:0]       merged;
  logic [DATA_W-1:0]       chk_src;
  logic [LANE_W-1:0]       chk;
  logic                    full_be;

  assign full_be = &req_be_i;

  wmask_merge #(.DATA_LANES(DATA_LANES), .LANE_W(LANE_W)) u_merge (
    .new_i    (data_q),
    .old_i    (rd_data_i),
    .be_i     (be_q),
    .merged_o (merged)
  );

  assign chk_src = (state_q == ST_WAIT) ? merged : req_data_i;

  wmask_check #(.DATA_LANES(DATA_LANES), .LANE_W(LANE_W)) u_check (
    .data_i (chk_src),
    .chk_o  (chk)
  );

  assign req_ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      be_q        <= '0;
      cmd_valid_o <= 1'b0;
      cmd_wr_o    <= 1'b0;
      cmd_addr_o  <= '0;
      wr_data_o   <= '0;
      dm_o        <= '0;
      dm_oe_o     <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      dm_oe_o     <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          cmd_valid_o <= 1'b1;
          cmd_addr_o  <= req_addr_i;
          if (!x4_mode_i || full_be) begin
            cmd_wr_o  <= 1'b1;
            dm_oe_o   <= 1'b1;
            wr_data_o <= {chk, req_data_i};
            dm_o      <= {~full_be, ~req_be_i};
          end else begin
            // no mask pins: fetch line first
            cmd_wr_o  <= 1'b0;
            wr_data_o <= '0;
            dm_o      <= '0;
            addr_q    <= req_addr_i;
            data_q    <= req_data_i;
            be_q      <= req_be_i;
            state_q   <= ST_WAIT;
          end
        end
        ST_WAIT: if (rd_valid_i) begin
          cmd_valid_o <= 1'b1;
          cmd_wr_o    <= 1'b1;
          cmd_addr_o  <= addr_q;
          dm_oe_o     <= 1'b1;
          wr_data_o   <= {chk, merged};
          dm_o        <= '0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wmask_rmw_sel_chk.sv
module wmask_rmw_sel_chk #(
  parameter int LANES = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             x4_mode_i,
  input logic             req_ready_o,
  input logic             rd_valid_i,
  input logic             cmd_valid_o,
  input logic             cmd_wr_o,
  input logic [LANES-1:0] dm_o,
  input logic             dm_oe_o
);
  // R7
  oe_matches_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_oe_o == (cmd_valid_o && cmd_wr_o));

  // R4
  read_holds_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_wr_o) |-> !req_ready_o);

  // R4
  stall_starts_with_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_ready_o) |-> (cmd_valid_o && !cmd_wr_o));

  // R8
  narrow_no_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_wr_o && x4_mode_i) |-> (dm_o == '0));

  // R5
  merge_write_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && rd_valid_i) |=> (cmd_valid_o && cmd_wr_o && dm_o == '0 && req_ready_o));

  // R9
  no_write_while_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !req_ready_o) |-> !cmd_wr_o);
endmodule

bind wmask_rmw_sel wmask_rmw_sel_chk #(.LANES(DATA_LANES + 1)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .x4_mode_i   (x4_mode_i),
  .req_ready_o (req_ready_o),
  .rd_valid_i  (rd_valid_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_wr_o    (cmd_wr_o),
  .dm_o        (dm_o),
  .dm_oe_o     (dm_oe_o)
);

// File: tb/tb_wmask_rmw_sel.sv
module tb_wmask_rmw_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        x4_mode_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [63:0] req_data_i = '0;
  logic [7:0]  req_be_i = '0;
  logic        rd_valid_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic        cmd_valid_o, cmd_wr_o, dm_oe_o;
  logic [31:0] cmd_addr_o;
  logic [71:0] wr_data_o;
  logic [8:0]  dm_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wmask_rmw_sel dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_new(input int be, input int m);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[i*8 +: 8] = 8'(be + i*37 + m*5 + 1);
    return d;
  endfunction

  function automatic logic [63:0] mk_old(input int be);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[i*8 +: 8] = 8'(8'hC3 ^ (i*19) ^ be);
    return d;
  endfunction

  function automatic logic [7:0] fold(input logic [63:0] d);
    logic [7:0] a = '0;
    for (int i = 0; i < 8; i++) a ^= d[i*8 +: 8];
    return a;
  endfunction

  task automatic one_req(input int m, input int be);
    logic [63:0] nd, od, mg;
    bit rmw;
    nd = mk_new(be, m);
    od = mk_old(be);
    rmw = (m == 1) && (be != 255);
    x4_mode_i   = m[0];
    req_valid_i = 1'b1;
    req_be_i    = 8'(be);
    req_data_i  = nd;
    req_addr_i  = 32'h1000 + 32'(be) * 64 + 32'(m);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R2 R3 R4 cmd_valid", 72'(cmd_valid_o), 72'd1);
    chk("R2 R4 addr", 72'(cmd_addr_o), 72'(32'h1000 + 32'(be) * 64 + 32'(m)));
    if (!rmw) begin
      chk("R2 R3 cmd_wr", 72'(cmd_wr_o), 72'd1);
      chk("R7 oe on write", 72'(dm_oe_o), 72'd1);
      chk("R2 R3 data", wr_data_o, {fold(nd), nd});
      if (be == 255) chk("R3 R8 full mask", 72'(dm_o), 72'd0);
      else           chk("R2 mask", 72'(dm_o), 72'({1'b1, ~8'(be)}));
    end else begin
      chk("R4 read cmd", 72'(cmd_wr_o), 72'd0);
      chk("R4 ready low", 72'(req_ready_o), 72'd0);
      chk("R7 oe off read", 72'(dm_oe_o), 72'd0);
      // R9: request during pending RMW must be ignored
      req_valid_i = 1'b1;
      req_be_i    = 8'hFF;
      @(negedge clk_i);
      req_valid_i = 1'b0;
      chk("R9 no cmd while pending", 72'(cmd_valid_o), 72'd0);
      chk("R4 ready held", 72'(req_ready_o), 72'd0);
      rd_valid_i = 1'b1;
      rd_data_i  = od;
      @(negedge clk_i);
      rd_valid_i = 1'b0;
      for (int i = 0; i < 8; i++) mg[i*8 +: 8] = be[i] ? nd[i*8 +: 8] : od[i*8 +: 8];
      chk("R5 merged write valid", 72'({cmd_valid_o, cmd_wr_o, dm_oe_o}), 72'd7);
      chk("R5 R8 mask zero", 72'(dm_o), 72'd0);
      chk("R5 R6 merged line", wr_data_o, {fold(mg), mg});
      chk("R5 addr", 72'(cmd_addr_o), 72'(32'h1000 + 32'(be) * 64 + 32'(m)));
      chk("R4 ready back", 72'(req_ready_o), 72'd1);
    end
    @(negedge clk_i);
    chk("R9 R7 idle after", 72'({cmd_valid_o, dm_oe_o}), 72'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 cmd_valid", 72'(cmd_valid_o), 72'd0);
    chk("R1 dm_oe", 72'(dm_oe_o), 72'd0);
    chk("R1 ready", 72'(req_ready_o), 72'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9: stray read return while idle
    rd_valid_i = 1'b1;
    rd_data_i  = 64'h0123_4567_89AB_CDEF;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    chk("R9 stray rd ignored", 72'({cmd_valid_o, req_ready_o}), 72'd1);
    for (int m = 0; m < 2; m++)
      for (int be = 0; be < 256; be++) one_req(m, be);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule